// File: doc/BRIEF.md
# Dual-Compare Timer with Modulator

This block is an up-counting timer. It advances by one on every cycle in which an external, already prescaled count enable is high. Two compare channels, A and B, watch the counter. Each channel has three enables of its own. The first clears the counter on a match. The second limits the channel to one match event until it is re-armed. The third inverts a single modulator flip-flop that both channels share. The timer can therefore produce periodic reloads, one-off events and a square or pulse-width waveform on `mod_out`.

A capture path picks one of four external sources with a two-bit field in the mode register. It passes that source through a two-flop synchronizer. On each rising edge it copies the counter into a capture register and raises a flag, and reading the capture register clears the flag. Software reaches the registers through a write strobe and a combinational read port.

Top module: `dcmp_timer`

## Requirements
- R1: After reset, every register reads 0 and `mod_out`, `match_a`, `match_b` and `cap_flag` are 0.
- R2: The counter increments by one, wrapping from all-ones to 0, on each cycle with `cnt_en` high and no reset-causing match. It holds its value while `cnt_en` is low.
- R3: When `cnt_en` is high and the counter equals a channel's compare value, that channel's match output is 1 for exactly the next cycle and then returns to 0.
- R4: A match on channel A with control bit 2 set, or on channel B with control bit 5 set, loads 0 into the counter instead of the increment. With the bit clear, the counter increments past the match.
- R5: With control bit 1 (A) or bit 4 (B) set, the channel produces at most one match event. Later equal counts give no event until software writes that bit from 0 to 1 or writes that channel's compare register.
- R6: A match on channel A with control bit 0 set, or on channel B with control bit 3 set, inverts `mod_out` on the same clock edge as the match output rises. With the bit clear, that channel leaves `mod_out` unchanged.
- R7: When both channels match in the same cycle with both toggle bits set, `mod_out` inverts once.
- R8: When both channels match in the same cycle and either has its reset bit set, the counter becomes 0.
- R9: Mode bits 7:6 select the capture source: 00 selects `cap_src[0]`, 01 selects `cap_src[1]`, 10 selects `cap_src[2]` and 11 selects `cap_src[3]`. A rising edge on the selected source copies the counter into the capture register on the third clock edge after it. Edges on unselected sources are ignored.
- R10: A capture sets `cap_flag`. A read of the capture register (address 4) clears it on that read's clock edge.
- R11: The register addresses are: 0 control, which has 6 bits and reads 0 above bit 5; 1 mode, 8 bits, all read/write; 2 compare A; 3 compare B; 4 capture, read-only; 5 counter, read-only. Writes to 4 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Read strobe; clears the capture flag when it addresses the capture register |
| rd_addr | input | 3 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| cnt_en | input | 1 | Prescaled count enable |
| cap_src | input | 4 | Capture source candidates |
| match_a | output | 1 | Channel A match pulse |
| match_b | output | 1 | Channel B match pulse |
| mod_out | output | 1 | Modulator flip-flop output |
| cap_flag | output | 1 | Capture-pending flag |

## Verification
The bound checker watches the counter on every cycle. It checks that the counter holds while the enable is low, that it steps by one when no compare value equals it, and that it lands on 0 after a match with the reset bit set. It also checks that the modulator changes only alongside a match pulse and changes state on a joint match with both toggle bits set. The one-shot lock, its two re-arm paths, capture-source selection, the synchronizer latency, the clear-on-read flag and the read-only addresses depend on register writes and sequences. Only the bench's scenarios can show those.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CTL_W  = 3 * NUM_CH;
  localparam int unsigned MODE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_MODE = 3'd1,
    REG_CMPA = 3'd2,
    REG_CMPB = 3'd3,
    REG_CAPT = 3'd4,
    REG_CNT  = 3'd5
  } reg_addr_e;

  // per-channel slice of the control register, MSB first: reset, one-shot, toggle
  typedef struct packed {
    logic rst;
    logic one;
    logic tgl;
  } ch_ctl_t;

  localparam int unsigned ONE_BIT = 1;

endpackage

// File: rtl/dcmp_channel.sv
module dcmp_channel
  import dcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  ch_ctl_t          ctl,
  input  logic             rearm,
  output logic             event_o,
  output logic             match_o
);

  logic lock_q, lock_d;
  logic match_q;

  always_comb begin
    event_o = cnt_en && (cnt == cmp) && !(ctl.one && lock_q);
    lock_d  = lock_q;
    if (rearm) begin
      lock_d = 1'b0;
    end else if (event_o && ctl.one) begin
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      lock_q  <= lock_d;
      match_q <= event_o;
    end
  end

  assign match_o = match_q;

endmodule

// File: rtl/dcmp_modulator.sv
module dcmp_modulator #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic [NCH-1:0] tgl_en,
  output logic           mod_o
);

  logic mod_q, mod_d;

  always_comb begin
    mod_d = mod_q;
    if (|(ev & tgl_en)) begin
      mod_d = !mod_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= 1'b0;
    end else begin
      mod_q <= mod_d;
    end
  end

  assign mod_o = mod_q;

endmodule

// File: rtl/dcmp_capture.sv
module dcmp_capture #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned NSRC   = 4,
  parameter int unsigned STAGES = 2,
  localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clr,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);

  logic              chosen;
  logic [STAGES:0]   sync_q, sync_d;
  logic              rise;
  logic [CNT_W-1:0]  cap_q, cap_d;
  logic              flag_q, flag_d;

  always_comb begin
    chosen = src[sel];
    sync_d = {sync_q[STAGES-1:0], chosen};
    rise   = sync_q[STAGES-1] && !sync_q[STAGES];
    cap_d  = cap_q;
    flag_d = flag_q;
    if (clr) begin
      flag_d = 1'b0;
    end
    if (rise) begin
      cap_d  = cnt;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/dcmp_timer.sv
module dcmp_timer
  import dcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cnt_en,
  input  logic [3:0]        cap_src,
  output logic              match_a,
  output logic              match_b,
  output logic              mod_out,
  output logic              cap_flag
);

  localparam int unsigned NSRC = 4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_ni = rsync_q[1];

  logic [CTL_W-1:0]  ctrl_q, ctrl_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic [CNT_W-1:0]  cmp_d [NUM_CH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NUM_CH-1:0] ev, rst_en, tgl_en, rearm, match_v;
  logic [CNT_W-1:0]  cap_val;
  logic              cap_clr;

  // per-channel compare logic
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ch_ctl_t ctl;
    logic    wr_cmp;
    logic    one_rise;

    assign ctl      = ch_ctl_t'(ctrl_q[3*ch +: 3]);
    assign wr_cmp   = wr_en && (wr_addr == 3'(int'(REG_CMPA) + ch));
    assign one_rise = wr_en && (wr_addr == REG_CTRL)
                      && wr_data[3*ch + ONE_BIT] && !ctrl_q[3*ch + ONE_BIT];
    assign rearm[ch]  = wr_cmp || one_rise;
    assign rst_en[ch] = ctl.rst;
    assign tgl_en[ch] = ctl.tgl;

    always_comb begin
      cmp_d[ch] = cmp_q[ch];
      if (wr_cmp) begin
        cmp_d[ch] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q[ch] <= '0;
      end else begin
        cmp_q[ch] <= cmp_d[ch];
      end
    end

    dcmp_channel #(.CNT_W(CNT_W)) chan_i (
      .clk     (clk),
      .rst_n   (rst_ni),
      .cnt_en  (cnt_en),
      .cnt     (cnt_q),
      .cmp     (cmp_q[ch]),
      .ctl     (ctl),
      .rearm   (rearm[ch]),
      .event_o (ev[ch]),
      .match_o (match_v[ch])
    );
  end

  // control, mode and counter next state
  always_comb begin
    ctrl_d = ctrl_q;
    mode_d = mode_q;
    if (wr_en && (wr_addr == REG_CTRL)) begin
      ctrl_d = wr_data[CTL_W-1:0];
    end
    if (wr_en && (wr_addr == REG_MODE)) begin
      mode_d = wr_data[MODE_W-1:0];
    end
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (|(ev & rst_en)) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  dcmp_modulator #(.NCH(NUM_CH)) mod_i (
    .clk    (clk),
    .rst_n  (rst_ni),
    .ev     (ev),
    .tgl_en (tgl_en),
    .mod_o  (mod_out)
  );

  assign cap_clr = rd_en && (rd_addr == REG_CAPT);

  dcmp_capture #(.CNT_W(CNT_W), .NSRC(NSRC), .STAGES(2)) cap_i (
    .clk    (clk),
    .rst_n  (rst_ni),
    .src    (cap_src),
    .sel    (mode_q[7:6]),
    .cnt    (cnt_q),
    .clr    (cap_clr),
    .cap_o  (cap_val),
    .flag_o (cap_flag)
  );

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: rd_data[CTL_W-1:0]  = ctrl_q;
      REG_MODE: rd_data[MODE_W-1:0] = mode_q;
      REG_CMPA: rd_data = cmp_q[0];
      REG_CMPB: rd_data = cmp_q[1];
      REG_CAPT: rd_data = cap_val;
      REG_CNT:  rd_data = cnt_q;
      default:  rd_data = '0;
    endcase
  end

  assign match_a = match_v[0];
  assign match_b = match_v[1];

endmodule

// File: rtl/dcmp_timer_chk.sv
module dcmp_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cmp_b,
  input logic [5:0]       ctrl_q,
  input logic             match_a,
  input logic             match_b,
  input logic             mod_out
);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && (cnt_q != cmp_a) && (cnt_q != cmp_b))
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2

  AST_RST_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_a && $past(ctrl_q[2])) || (match_b && $past(ctrl_q[5])))
      |-> (cnt_q == '0)); // R4

  AST_MOD_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_out) |-> (match_a || match_b)); // R6

  AST_JOINT_SINGLE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && match_b && $past(ctrl_q[0]) && $past(ctrl_q[3]))
      |-> (mod_out != $past(mod_out))); // R7

endmodule

bind dcmp_timer dcmp_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_ni),
  .cnt_en  (cnt_en),
  .cnt_q   (cnt_q),
  .cmp_a   (cmp_q[0]),
  .cmp_b   (cmp_q[1]),
  .ctrl_q  (ctrl_q),
  .match_a (match_a),
  .match_b (match_b),
  .mod_out (mod_out)
);

// File: tb/dcmp_timer_tb_top.sv
`timescale 1ns/1ps
module dcmp_timer_tb_top;

  localparam int CNT_W = 8;
  localparam int WATCHDOG_CYC = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [2:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic             cnt_en = 1'b0;
  logic [3:0]       cap_src = '0;
  logic             match_a, match_b, mod_out, cap_flag;

  always #2.5 clk = ~clk;

  dcmp_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_en(cnt_en), .cap_src(cap_src), .match_a(match_a), .match_b(match_b),
    .mod_out(mod_out), .cap_flag(cap_flag)
  );

  // sources the monitor can compare
  localparam int S_RD = 0, S_MA = 1, S_MB = 2, S_MOD = 3, S_CF = 4;

  typedef struct {
    int    src;
    int    exp;
    string tag;
  } item_t;

  item_t exp_q[$];
  event  mon_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  task automatic push_exp(int src, int exp, string tag);
    item_t it;
    it.src = src; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    -> mon_ev;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(mon_ev);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        int act;
        it = exp_q.pop_front();
        case (it.src)
          S_RD:    act = int'(rd_data);
          S_MA:    act = int'(match_a);
          S_MB:    act = int'(match_b);
          S_MOD:   act = int'(mod_out);
          default: act = int'(cap_flag);
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = CNT_W'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic step(bit en);
    @(negedge clk);
    cnt_en = en;
    @(posedge clk); #1;
    cnt_en = 1'b0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  task automatic rd_chk(int a, int exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'(a);
    push_exp(S_RD, exp, tag);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wait_sync();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    for (int a = 0; a < 6; a++) rd_chk(a, 0, "R1 register after reset");
    @(negedge clk);
    push_exp(S_MOD, 0, "R1 mod_out"); push_exp(S_CF, 0, "R1 cap_flag");
    push_exp(S_MA, 0, "R1 match_a");  push_exp(S_MB, 0, "R1 match_b");

    // R11 register map
    wr(1, 8'hA5); rd_chk(1, 8'hA5, "R11 mode rw");
    wr(0, 8'hFF); rd_chk(0, 8'h3F, "R11 ctrl width");
    wr(4, 8'h55); rd_chk(4, 0, "R11 capture read-only");
    wr(5, 8'h33); rd_chk(5, 0, "R11 counter read-only");
    wr(0, 0); wr(1, 0);
    wr(2, 10); wr(3, 20);
    rd_chk(2, 10, "R11 cmpA"); rd_chk(3, 20, "R11 cmpB");

    // R2 count and hold
    steps(3); rd_chk(5, 3, "R2 count");
    step(1'b0); step(1'b0); rd_chk(5, 3, "R2 hold");

    // R3 match pulse
    steps(7); step(1'b1);
    @(negedge clk);
    push_exp(S_MA, 1, "R3 match_a pulse"); push_exp(S_MB, 0, "R3 match_b quiet");
    step(1'b1);
    @(negedge clk); push_exp(S_MA, 0, "R3 pulse one cycle");
    rd_chk(5, 12, "R4 no reset when bit clear");

    // R6 toggle
    wr(0, 8'h01); wr(2, 13);
    steps(1); step(1'b1);
    @(negedge clk); push_exp(S_MOD, 1, "R6 toggle on A");
    wr(0, 0); wr(2, 15);
    steps(1); step(1'b1);
    @(negedge clk);
    push_exp(S_MA, 1, "R6 match seen"); push_exp(S_MOD, 1, "R6 toggle off no effect");

    // R4 reset on match
    wr(0, 8'h04); wr(2, 18);
    steps(2); step(1'b1);
    rd_chk(5, 0, "R4 reset on A");
    wr(0, 0); wr(2, 2);
    steps(3); rd_chk(5, 3, "R4 reset bit clear");

    // R5 one-shot
    wr(0, 8'h02); wr(2, 5);
    steps(2); step(1'b1);
    @(negedge clk); push_exp(S_MA, 1, "R5 first event");
    wr(0, 8'h22); wr(3, 7);
    steps(2);                 // 6->7, match B resets to 0
    steps(5); step(1'b1);
    @(negedge clk); push_exp(S_MA, 0, "R5 locked no event");
    rd_chk(5, 6, "R5 count after locked");
    wr(0, 8'h20); wr(0, 8'h22);
    steps(2); steps(5); step(1'b1);
    @(negedge clk); push_exp(S_MA, 1, "R5 rearm by bit rise");

    // R7 joint toggle
    wr(0, 8'h09); wr(2, 8); wr(3, 8);
    steps(2); step(1'b1);
    @(negedge clk);
    push_exp(S_MA, 1, "R7 match_a"); push_exp(S_MB, 1, "R7 match_b");
    push_exp(S_MOD, 0, "R7 single toggle");

    // R8 joint reset
    wr(0, 8'h20); wr(2, 11); wr(3, 11);
    steps(2); step(1'b1);
    rd_chk(5, 0, "R8 joint reset");

    // R2 wrap
    wr(0, 0); wr(2, 8'h80); wr(3, 8'h80);
    steps(255); rd_chk(5, 255, "R2 top value");
    step(1'b1); rd_chk(5, 0, "R2 wrap");

    // R9 / R10 capture
    steps(5);
    @(negedge clk); cap_src[0] = 1'b1;
    wait_sync();
    @(negedge clk); push_exp(S_CF, 1, "R10 flag set");
    rd_chk(4, 5, "R9 capture src0");
    @(negedge clk); push_exp(S_CF, 0, "R10 flag cleared on read");
    @(negedge clk); cap_src[0] = 1'b0;
    wait_sync();
    wr(1, 8'hC0); steps(2);
    @(negedge clk); cap_src[0] = 1'b1;
    wait_sync();
    @(negedge clk); push_exp(S_CF, 0, "R9 unselected ignored");
    rd_chk(4, 5, "R9 capture unchanged");
    @(negedge clk); cap_src[0] = 1'b0; cap_src[3] = 1'b1;
    wait_sync();
    @(negedge clk); push_exp(S_CF, 1, "R9 src3 flag");
    rd_chk(4, 7, "R9 capture src3");
    @(negedge clk); cap_src[3] = 1'b0;
    wait_sync();
    wr(1, 8'h40); steps(1);
    @(negedge clk); cap_src[1] = 1'b1;
    wait_sync();
    rd_chk(4, 8, "R9 capture src1");
    rd_chk(1, 8'h40, "R11 mode readback");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule